// File: doc/BRIEF.md
# Byte-Stream Transaction Bus Master

This block sits behind a byte-level packet decoder. It receives one request per packet as a stream of bytes. Each packet is marked with start and end flags. The first eight bytes of the packet form a header: an opcode, a byte count and a target address. The block turns the request into 32-bit accesses on a simple memory-mapped bus. The bus port has a stall input that holds a request in place, and a separate read-data-valid return.

A write request carries its data words after the header. The block issues one bus write per complete word, then answers with a four-byte status packet. That packet echoes the opcode with its top bit flipped and reports how many bytes were written. A read request is the header alone. The block issues the reads and streams the returned words back as a bare packet, with no header. An opcode that names no access, or a request of zero words, produces only the status packet, with a zero count.

Top module: `txb_bridge`

## Requirements
- R1: A packet begins at a byte flagged start, and bytes seen before any start flag are dropped. A new start flag inside the header restarts the header. Header byte 0 is the opcode and byte 1 is ignored. Bytes 2..3 are the byte count, most significant first. Bytes 4..7 are the address, most significant first.
- R2: Opcode 0x00 writes exactly one word at the header address when the count is at least 4. Payload bytes arrive least significant first. Payload beyond the first word is consumed without a bus access.
- R3: Opcode 0x04 writes count/4 words, one bus write per word, and the address grows by 4 for each word.
- R4: A write-class request ends with a 4-byte response: opcode XOR 0x80, then 0x00, then the written byte count, most significant byte first. Start is flagged on the first byte and end on the last.
- R5: Opcode 0x10 reads one word and returns exactly its 4 bytes, least significant first, flagged start on the first byte and end on the last. Extra bytes after the header are consumed before the access.
- R6: Opcode 0x14 reads count/4 words at addresses that grow by 4. The words are returned back to back. Start is flagged only on the very first byte and end only on the very last byte.
- R7: Opcode 0x7F, any other unlisted opcode, and a known opcode whose count is below 4 all produce the 4-byte response with a zero count and no bus access.
- R8: While the stall input is high, a bus request stays asserted with stable address and write data. Each word produces exactly one accepted access.
- R9: While the output ready input is low, a presented output byte and its flags stay unchanged.
- R10: If the end flag arrives inside the write payload, only the complete words before it are written. The response count reports only those bytes.
- R11: A packet whose end flag arrives before the eighth header byte is dropped with no response and no bus access.
- R12: No input byte is accepted while a bus access is in flight or a response byte is pending.
- R13: Counts above MAX_WORDS*4 are clamped to MAX_WORDS words (256 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts an input byte |
| in_sop | input | 1 | Input byte is first of packet |
| in_eop | input | 1 | Input byte is last of packet |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink accepts an output byte |
| out_sop | output | 1 | Output byte is first of packet |
| out_eop | output | 1 | Output byte is last of packet |
| out_data | output | 8 | Output byte |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_write | output | 1 | Bus write request |
| bus_read | output | 1 | Bus read request |
| bus_wdata | output | 32 | Bus write data |
| bus_stall | input | 1 | Bus holds the current request |
| bus_rdata | input | 32 | Bus read data |
| bus_rvalid | input | 1 | Bus read data valid |

## Verification
The assertions check, on every cycle, the handshake rules that hold in any situation: requests and output bytes stay unchanged while stalled, read and write are never requested together, and no input byte is accepted while an access or a response is pending. Other behaviours depend on the request, so only the bench's scenarios can show them. These include header field order, payload byte order, the address step, response encoding and flags, clamping, truncated payloads and dropped short packets. The bench compares each response and each bus access log against values it derives from the request.

// File: rtl/txb_pkg.sv
`timescale 1ns/1ps
package txb_pkg;
  localparam logic [7:0] OPC_WR     = 8'h00;
  localparam logic [7:0] OPC_WR_SEQ = 8'h04;
  localparam logic [7:0] OPC_RD     = 8'h10;
  localparam logic [7:0] OPC_RD_SEQ = 8'h14;
  localparam logic [7:0] OPC_NOP    = 8'h7F;
  localparam logic [7:0] RESP_FLIP  = 8'h80;
  localparam int HDR_BYTES  = 8;
  localparam int WORD_BYTES = 4;

  typedef enum logic [3:0] {
    ST_HDR, ST_DRAIN, ST_WDATA, ST_WBUS, ST_WSKIP,
    ST_RBUS, ST_RWAIT, ST_RSEND, ST_RESP, ST_FLUSH
  } txb_state_e;

  typedef enum logic [1:0] {K_NONE, K_WRITE, K_READ} txb_kind_e;
endpackage

// File: rtl/txb_hdr_capture.sv
`timescale 1ns/1ps
module txb_hdr_capture
  import txb_pkg::*;
#(
  parameter int IDX_W = $clog2(HDR_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       din,
  output logic [7:0]       opcode,
  output logic [13:0]      word_cnt,
  output logic [31:0]      addr_fwd
);
  logic [7:0]  op_q;
  logic [13:0] cnt_q;
  logic [31:0] adr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= '0;
      cnt_q <= '0;
      adr_q <= '0;
    end else if (load) begin
      case (idx)
        IDX_W'(0): op_q          <= din;
        IDX_W'(2): cnt_q[13:6]   <= din;
        IDX_W'(3): cnt_q[5:0]    <= din[7:2];
        IDX_W'(4): adr_q[31:24]  <= din;
        IDX_W'(5): adr_q[23:16]  <= din;
        IDX_W'(6): adr_q[15:8]   <= din;
        IDX_W'(7): adr_q[7:0]    <= din;
        default: ;
      endcase
    end
  end

  assign opcode   = op_q;
  assign word_cnt = cnt_q;
  // last address byte forwarded so the access can start right after the header
  assign addr_fwd = {adr_q[31:8], (load && idx == IDX_W'(7)) ? din : adr_q[7:0]};
endmodule

// File: rtl/txb_word_asm.sv
`timescale 1ns/1ps
module txb_word_asm #(
  parameter int LANES  = 4,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               en,
  input  logic [7:0]         din,
  output logic [8*LANES-1:0] word,
  output logic               last_lane
);
  logic [LANE_W-1:0] lane_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lane_q <= '0;
    end else if (en) begin
      lane_q <= (lane_q == LANE_W'(LANES-1)) ? '0 : lane_q + 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        word[8*g +: 8] <= '0;
      end else if (en && lane_q == LANE_W'(g)) begin
        word[8*g +: 8] <= din;
      end
    end
  end

  assign last_lane = (lane_q == LANE_W'(LANES-1));
endmodule

// File: rtl/txb_byte_ser.sv
`timescale 1ns/1ps
module txb_byte_ser #(
  parameter int LANES  = 4,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [8*LANES-1:0] word_in,
  input  logic               first_in,
  input  logic               last_in,
  input  logic               out_ready,
  output logic               out_valid,
  output logic               out_sop,
  output logic               out_eop,
  output logic [7:0]         out_data
);
  logic [8*LANES-1:0] sh_q;
  logic [LANE_W-1:0]  rem_q;
  logic               vld_q, sop_q, eop_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      rem_q  <= '0;
      vld_q  <= 1'b0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (load) begin
      sh_q   <= word_in;
      rem_q  <= LANE_W'(LANES-1);
      vld_q  <= 1'b1;
      sop_q  <= first_in;
      eop_q  <= last_in && (LANES == 1);
      last_q <= last_in;
    end else if (vld_q && out_ready) begin
      sop_q <= 1'b0;
      if (rem_q == '0) begin
        vld_q <= 1'b0;
        eop_q <= 1'b0;
      end else begin
        sh_q  <= sh_q >> 8;
        rem_q <= rem_q - 1'b1;
        eop_q <= last_q && (rem_q == LANE_W'(1));
      end
    end
  end

  assign out_valid = vld_q;
  assign out_sop   = sop_q;
  assign out_eop   = eop_q;
  assign out_data  = sh_q[7:0];
endmodule

// File: rtl/txb_bridge.sv
`timescale 1ns/1ps
module txb_bridge
  import txb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic              out_eop,
  output logic [7:0]        out_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic              bus_read,
  output logic [31:0]       bus_wdata,
  input  logic              bus_stall,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_rvalid
);
  localparam int DATA_W = 8 * WORD_BYTES;
  localparam int WC_W   = $clog2(MAX_WORDS + 1);
  localparam int HIDX_W = $clog2(HDR_BYTES);

  txb_state_e        state;
  txb_kind_e         kind_q, dec_kind;
  logic [HIDX_W-1:0] hidx, hdr_idx;
  logic [WC_W-1:0]   words_left, words_done, dec_words;
  logic [ADDR_W-1:0] addr_r;
  logic              eop_seen;

  logic              acc, hdr_load, hdr_done;
  logic [7:0]        hdr_op;
  logic [13:0]       hdr_words;
  logic [31:0]       hdr_addr;
  logic              is_wr, is_rd, is_single;

  logic [DATA_W-1:0] asm_word;
  logic              asm_last, asm_en;

  logic              ser_load, ser_first, ser_last, ser_busy;
  logic [DATA_W-1:0] ser_word, resp_word;
  logic [15:0]       resp_cnt;
  logic [7:0]        resp_code;

  assign in_ready  = (state == ST_HDR) || (state == ST_DRAIN) ||
                     (state == ST_WDATA) || (state == ST_WSKIP);
  assign acc       = in_valid && in_ready;
  assign hdr_load  = acc && (state == ST_HDR) && (in_sop || hidx != '0);
  assign hdr_idx   = in_sop ? '0 : hidx;
  assign hdr_done  = hdr_load && (hdr_idx == HIDX_W'(HDR_BYTES-1));

  txb_hdr_capture #(.IDX_W(HIDX_W)) u_hdr (
    .clk     (clk),
    .rst     (rst),
    .load    (hdr_load),
    .idx     (hdr_idx),
    .din     (in_data),
    .opcode  (hdr_op),
    .word_cnt(hdr_words),
    .addr_fwd(hdr_addr)
  );

  // opcode decode and word-count clamp
  assign is_wr     = (hdr_op == OPC_WR) || (hdr_op == OPC_WR_SEQ);
  assign is_rd     = (hdr_op == OPC_RD) || (hdr_op == OPC_RD_SEQ);
  assign is_single = (hdr_op == OPC_WR) || (hdr_op == OPC_RD);

  always_comb begin
    if (is_single)
      dec_words = (hdr_words != '0) ? WC_W'(1) : '0;
    else if (hdr_words > 14'(MAX_WORDS))
      dec_words = WC_W'(MAX_WORDS);
    else
      dec_words = WC_W'(hdr_words);
    if (is_wr && dec_words != '0)      dec_kind = K_WRITE;
    else if (is_rd && dec_words != '0) dec_kind = K_READ;
    else                               dec_kind = K_NONE;
  end

  assign asm_en = acc && (state == ST_WDATA);

  txb_word_asm #(.LANES(WORD_BYTES)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .clr      (hdr_done),
    .en       (asm_en),
    .din      (in_data),
    .word     (asm_word),
    .last_lane(asm_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HDR;
      hidx       <= '0;
      kind_q     <= K_NONE;
      words_left <= '0;
      words_done <= '0;
      addr_r     <= '0;
      eop_seen   <= 1'b0;
    end else begin
      case (state)
        ST_HDR: begin
          if (hdr_done) begin
            hidx       <= '0;
            kind_q     <= dec_kind;
            words_left <= dec_words;
            words_done <= '0;
            addr_r     <= hdr_addr[ADDR_W-1:0];
            eop_seen   <= 1'b0;
            if (in_eop)
              state <= (dec_kind == K_READ) ? ST_RBUS : ST_RESP;
            else
              state <= (dec_kind == K_WRITE) ? ST_WDATA : ST_DRAIN;
          end else if (hdr_load) begin
            hidx <= in_eop ? '0 : hdr_idx + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (acc && in_eop)
            state <= (kind_q == K_READ) ? ST_RBUS : ST_RESP;
        end
        ST_WDATA: begin
          if (acc) begin
            if (asm_last) begin
              eop_seen <= in_eop;
              state    <= ST_WBUS;
            end else if (in_eop) begin
              state <= ST_RESP;
            end
          end
        end
        ST_WBUS: begin
          if (!bus_stall) begin
            words_left <= words_left - 1'b1;
            words_done <= words_done + 1'b1;
            addr_r     <= addr_r + ADDR_W'(WORD_BYTES);
            if (eop_seen)                      state <= ST_RESP;
            else if (words_left == WC_W'(1))   state <= ST_WSKIP;
            else                               state <= ST_WDATA;
          end
        end
        ST_WSKIP: begin
          if (acc && in_eop) state <= ST_RESP;
        end
        ST_RBUS: begin
          if (!bus_stall) state <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (bus_rvalid) begin
            words_left <= words_left - 1'b1;
            words_done <= words_done + 1'b1;
            addr_r     <= addr_r + ADDR_W'(WORD_BYTES);
            state      <= ST_RSEND;
          end
        end
        ST_RSEND: begin
          if (!ser_busy) state <= (words_left == '0) ? ST_HDR : ST_RBUS;
        end
        ST_RESP:  state <= ST_FLUSH;
        ST_FLUSH: begin
          if (!ser_busy) state <= ST_HDR;
        end
        default:  state <= ST_HDR;
      endcase
    end
  end

  // response header packed so that the serializer emits it byte 0 first
  assign resp_cnt  = 16'({words_done, 2'b00});
  assign resp_code = hdr_op ^ RESP_FLIP;
  assign resp_word = {resp_cnt[7:0], resp_cnt[15:8], 8'h00, resp_code};

  assign ser_load  = (state == ST_RESP) || (state == ST_RWAIT && bus_rvalid);
  assign ser_word  = (state == ST_RESP) ? resp_word : bus_rdata;
  assign ser_first = (state == ST_RESP) || (words_done == '0);
  assign ser_last  = (state == ST_RESP) || (words_left == WC_W'(1));

  txb_byte_ser #(.LANES(WORD_BYTES)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .load     (ser_load),
    .word_in  (ser_word),
    .first_in (ser_first),
    .last_in  (ser_last),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_sop  (out_sop),
    .out_eop  (out_eop),
    .out_data (out_data)
  );

  assign ser_busy  = out_valid;
  assign bus_write = (state == ST_WBUS);
  assign bus_read  = (state == ST_RBUS);
  assign bus_addr  = addr_r;
  assign bus_wdata = asm_word;
endmodule

// File: rtl/txb_checks.sv
`timescale 1ns/1ps
module txb_checks #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sop,
  input logic              out_eop,
  input logic [7:0]        out_data,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic              bus_read,
  input logic [31:0]       bus_wdata,
  input logic              bus_stall
);
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    !(bus_write && bus_read)); // R8

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_write && bus_stall |=> bus_write && $stable(bus_addr) && $stable(bus_wdata)); // R8

  AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_read && bus_stall |=> bus_read && $stable(bus_addr)); // R8

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)); // R9

  AST_INPUT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (bus_write || bus_read || out_valid) |-> !in_ready); // R12
endmodule

bind txb_bridge txb_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_sop  (out_sop),
  .out_eop  (out_eop),
  .out_data (out_data),
  .bus_addr (bus_addr),
  .bus_write(bus_write),
  .bus_read (bus_read),
  .bus_wdata(bus_wdata),
  .bus_stall(bus_stall)
);

// File: tb/txb_bridge_test.sv
`timescale 1ns/1ps
module txb_bridge_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic out_valid, out_sop, out_eop;
  logic out_ready = 1'b0;
  logic [7:0] out_data;
  logic [31:0] bus_addr, bus_wdata;
  logic bus_write, bus_read;
  logic bus_stall = 1'b0;
  logic [31:0] bus_rdata = 32'h0;
  logic bus_rvalid = 1'b0;

  always #5 clk = ~clk;

  txb_bridge uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_read(bus_read), .bus_wdata(bus_wdata),
    .bus_stall(bus_stall), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  int checks = 0, fails = 0, blocked_viol = 0;
  bit finished = 0;

  logic [9:0]  txq[$];
  logic [9:0]  rxq[$];
  logic [9:0]  exp_rx[$];
  logic [63:0] wr_log[$];
  logic [63:0] exp_wr[$];
  logic [31:0] rd_log[$];
  logic [31:0] exp_rd[$];
  logic [31:0] mem_s [logic [31:0]];
  logic [31:0] mem_m [logic [31:0]];

  function automatic logic [31:0] fill_val(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return fill_val(a);
  endfunction

  function automatic int words_of(input logic [7:0] op, input logic [15:0] cnt);
    int w = int'(cnt >> 2);
    if (op == 8'h00 || op == 8'h10) w = (w != 0) ? 1 : 0;
    if (w > 256) w = 256;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus slave: random stall, random read latency
  bit rd_pend = 0;
  int rd_lat = 0;
  logic [31:0] rd_addr;
  always @(negedge clk) begin
    if (rst) begin
      bus_stall = 1'b0; bus_rvalid = 1'b0; rd_pend = 0;
    end else begin
      bus_rvalid = 1'b0;
      if (rd_pend) begin
        if (rd_lat == 0) begin
          bus_rvalid = 1'b1;
          bus_rdata  = mem_s.exists(rd_addr) ? mem_s[rd_addr] : fill_val(rd_addr);
          rd_pend    = 0;
        end else rd_lat--;
      end
      bus_stall = ($urandom_range(0, 9) < 3);
      if (bus_write && !bus_stall) begin
        wr_log.push_back({bus_addr, bus_wdata});
        mem_s[bus_addr] = bus_wdata;
      end
      if (bus_read && !bus_stall) begin
        rd_log.push_back(bus_addr);
        rd_pend = 1; rd_lat = $urandom_range(0, 3); rd_addr = bus_addr;
      end
    end
  end

  // output sink with random backpressure
  always @(negedge clk) begin
    if (rst) out_ready = 1'b0;
    else begin
      out_ready = ($urandom_range(0, 9) < 7);
      if (out_valid && out_ready) rxq.push_back({out_sop, out_eop, out_data});
      if (out_valid && in_ready) blocked_viol++;
    end
  end

  task automatic send_all();
    logic [9:0] b;
    while (txq.size() > 0) begin
      b = txq.pop_front();
      if ($urandom_range(0, 3) == 0) begin in_valid = 1'b0; @(negedge clk); end
      in_valid = 1'b1; in_sop = b[9]; in_eop = b[8]; in_data = b[7:0];
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  // builds one request, its expected bus log and response, runs and compares
  task automatic do_txn(input logic [7:0] op, input logic [15:0] cnt, input logic [31:0] addr,
                        input int npay, input int junk, input bit restart, input string tag);
    int w, nwr, idx;
    logic [7:0] hdr[8];
    logic [31:0] pw, rv;
    logic [15:0] rc;
    bit ok;
    w = words_of(op, cnt);
    for (int j = 0; j < junk; j++)
      txq.push_back({restart && j == 0, 1'b0, 8'($urandom)});
    hdr = '{op, 8'hA5, cnt[15:8], cnt[7:0], addr[31:24], addr[23:16], addr[15:8], addr[7:0]};
    for (int j = 0; j < 8; j++)
      txq.push_back({j == 0, (j == 7) && (npay == 0), hdr[j]});
    nwr = 0;
    for (int j = 0; j < npay; j += 4) begin
      pw = $urandom;
      for (int k = 0; k < 4 && j + k < npay; k++)
        txq.push_back({1'b0, (j + k == npay - 1), pw[8*k +: 8]});
      if ((op == 8'h00 || op == 8'h04) && j + 4 <= npay && nwr < w) begin
        exp_wr.push_back({addr + 32'(4*nwr), pw});
        mem_m[addr + 32'(4*nwr)] = pw;
        nwr++;
      end
    end
    if ((op == 8'h10 || op == 8'h14) && w > 0) begin
      for (int i = 0; i < w; i++) begin
        exp_rd.push_back(addr + 32'(4*i));
        rv = model_rd(addr + 32'(4*i));
        for (int k = 0; k < 4; k++)
          exp_rx.push_back({(i == 0 && k == 0), (i == w-1 && k == 3), rv[8*k +: 8]});
      end
    end else begin
      rc = 16'(nwr * 4);
      exp_rx.push_back({2'b10, op ^ 8'h80});
      exp_rx.push_back({2'b00, 8'h00});
      exp_rx.push_back({2'b00, rc[15:8]});
      exp_rx.push_back({2'b01, rc[7:0]});
    end
    send_all();
    idx = 0;
    while (rxq.size() < exp_rx.size() && idx < 20000) begin @(negedge clk); idx++; end
    repeat (20) @(negedge clk);
    ok = (rxq.size() == exp_rx.size());
    idx = -1;
    for (int i = 0; i < exp_rx.size() && i < rxq.size(); i++)
      if (idx < 0 && rxq[i] !== exp_rx[i]) idx = i;
    if (idx >= 0) ok = 0;
    if (idx >= 0) chk(ok, {tag, " response byte"}, 64'(rxq[idx]), 64'(exp_rx[idx]));
    else chk(ok, {tag, " response length"}, 64'(rxq.size()), 64'(exp_rx.size()));
    ok = (wr_log.size() == exp_wr.size());
    for (int i = 0; i < exp_wr.size() && i < wr_log.size(); i++) if (wr_log[i] !== exp_wr[i]) ok = 0;
    chk(ok, {tag, "/R8 write accesses"}, (wr_log.size() > 0) ? wr_log[0] : 64'(wr_log.size()),
        (exp_wr.size() > 0) ? exp_wr[0] : 64'(exp_wr.size()));
    ok = (rd_log.size() == exp_rd.size());
    for (int i = 0; i < exp_rd.size() && i < rd_log.size(); i++) if (rd_log[i] !== exp_rd[i]) ok = 0;
    chk(ok, {tag, "/R8 read accesses"}, 64'(rd_log.size()), 64'(exp_rd.size()));
    rxq.delete(); exp_rx.delete(); wr_log.delete(); exp_wr.delete(); rd_log.delete(); exp_rd.delete();
  endtask

  task automatic do_short(input string tag);
    logic [7:0] b[5];
    bit ok;
    b = '{8'h04, 8'h00, 8'h00, 8'h08, 8'h00};
    for (int j = 0; j < 5; j++) txq.push_back({j == 0, j == 4, b[j]});
    send_all();
    repeat (40) @(negedge clk);
    ok = (rxq.size() == 0) && (wr_log.size() == 0) && (rd_log.size() == 0);
    chk(ok, {tag, " short packet dropped"}, 64'(rxq.size() + wr_log.size() + rd_log.size()), 64'(0));
    rxq.delete(); wr_log.delete(); rd_log.delete();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1, "reset in_ready", 64'(in_ready), 64'(1));
    chk(out_valid === 1'b0, "reset out_valid", 64'(out_valid), 64'(0));
    chk(bus_write === 1'b0, "reset bus_write", 64'(bus_write), 64'(0));
    chk(bus_read === 1'b0, "reset bus_read", 64'(bus_read), 64'(0));

    do_txn(8'h00, 16'd4,  32'h0000_0100, 4,  0, 0, "R2 R4 single write");
    do_txn(8'h00, 16'd8,  32'h0000_0104, 8,  0, 0, "R2 extra payload dropped");
    do_txn(8'h04, 16'd16, 32'h0000_0200, 16, 0, 0, "R3 sequential write");
    do_txn(8'h10, 16'd4,  32'h0000_0100, 0,  0, 0, "R5 single read");
    do_txn(8'h10, 16'd4,  32'h0000_0104, 6,  0, 0, "R5 trailing bytes drained");
    do_txn(8'h14, 16'd16, 32'h0000_0200, 0,  0, 0, "R6 sequential read");
    do_txn(8'h14, 16'd1024, 32'h0001_0000, 0, 0, 0, "R6 full-length read");
    do_txn(8'h14, 16'hFFFC, 32'h0002_0000, 0, 0, 0, "R13 count clamp");
    do_txn(8'h7F, 16'd8,  32'h0000_0300, 0,  0, 0, "R7 no-transaction");
    do_txn(8'h33, 16'd8,  32'h0000_0300, 4,  0, 0, "R7 unknown opcode");
    do_txn(8'h14, 16'd2,  32'h0000_0300, 0,  0, 0, "R7 zero-word read");
    do_txn(8'h04, 16'd16, 32'h0000_0400, 9,  0, 0, "R10 early end in payload");
    do_short("R11");
    do_txn(8'h04, 16'd8,  32'h1234_5678, 8,  3, 0, "R1 junk before start");
    do_txn(8'h14, 16'd8,  32'h1234_5678, 0,  4, 1, "R1 restart in header");

    for (int n = 0; n < 40; n++) begin
      logic [7:0] op;
      logic [15:0] cnt;
      int w, np;
      case ($urandom_range(0, 5))
        0: op = 8'h00; 1: op = 8'h04; 2: op = 8'h10; 3: op = 8'h14; 4: op = 8'h7F;
        default: op = 8'($urandom);
      endcase
      cnt = 16'($urandom_range(0, 48));
      w = words_of(op, cnt);
      if (op == 8'h00 || op == 8'h04)
        np = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 4*w) : 4*w;
      else
        np = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 5) : 0;
      do_txn(op, cnt, {16'h0, 12'($urandom), 4'h0}, np, $urandom_range(0, 1), 0, "R9 random");
    end

    chk(blocked_viol == 0, "R12 input blocked while output pending", 64'(blocked_viol), 64'(0));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule